// File: doc/BRIEF.md
# UART Receive Character Buffer with Inactivity Timeout

This block is the receive-side store of a high-speed 8N1 serial port. A deserializer upstream hands it one character at a time, each with a framing-error flag and a break flag. The characters are kept in a first-in first-out store of 64 entries. The store raises a level request when its fill reaches a programmable threshold. It raises a separate request when characters have sat unread for a programmable number of character times.

Software, or a bus decoder in front of the block, reads a single 11-bit word that presents the oldest character together with its flags and an empty indication. A read strobe pops that character. The current fill count is also available as a level value. A character that arrives while the store is full is dropped, and a one-cycle overrun pulse reports the loss.

The inactivity timer is a three-state machine. In state `TM_IDLE` the store is empty or the timeout is disabled. In `TM_RUN` it counts character ticks. In `TM_FIRE` the timeout request is active. Its transitions are:
- `TM_IDLE -> TM_RUN` when the store holds data and a timeout code is selected.
- `TM_RUN -> TM_FIRE` when the tick that completes the selected count arrives with no activity in the same cycle.
- `TM_FIRE -> TM_RUN` when a character arrives or a read is made.
- `TM_RUN` or `TM_FIRE` `-> TM_IDLE` when the store is empty or the timeout is disabled.

Activity while in `TM_RUN` clears the tick count.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset the fill count is 0, the read word is 0x100, and the trigger, timeout and overrun outputs are low.
- R2: Characters are read in arrival order. The read word holds the character in bits 7:0, a zero empty flag in bit 8, the framing-error flag in bit 9 and the break flag in bit 10. A read strobe removes the character that was presented.
- R3: While the store is empty the read word is 0x100 (bit 8 set, all other bits zero). A read strobe then changes nothing.
- R4: `fill_count` gives the number of stored characters, zero-extended. Up to 64 characters can be stored.
- R5: A character presented while the fill is 64 is discarded, even if a read occurs in the same cycle. The stored contents and the fill count are left unchanged, and `overrun` is high for exactly the one cycle after that clock edge.
- R6: `trig_req` is high exactly while the fill is at least the selected threshold. Codes 0 to 5 of `trig_sel` select 1, 4, 8, 16, 32 and 48 characters; codes 6 and 7 also select 48. The request drops as soon as reads lower the fill below the threshold.
- R7: `tmo_sel` codes 1, 2 and 3 select 4, 8 and 16 character ticks. `tmo_req` rises on the clock edge of the tick that completes the selected number of ticks with no character and no read since the last activity. Code 0 keeps `tmo_req` low.
- R8: Every arriving character and every read clears the inactivity count, and a pending timeout request is withdrawn at that edge.
- R9: Ticks are counted only while the store holds data. When a read empties the store the timeout request is low from that edge onwards, and ticks into an empty store never raise it.
- R10: A character and a read in the same cycle on a store that is neither empty nor full leave the fill count unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received character is presented this cycle |
| in_byte | input | 8 | Received character |
| in_frame_err | input | 1 | Character had a framing error |
| in_break | input | 1 | Character was a break condition |
| char_tick | input | 1 | One-cycle pulse per character time |
| rd_en | input | 1 | Pop the presented character |
| trig_sel | input | 3 | Trigger threshold code |
| tmo_sel | input | 2 | Inactivity timeout code |
| rd_word | output | 11 | {break, error, empty, character} of the oldest entry |
| fill_count | output | 8 | Number of stored characters |
| trig_req | output | 1 | Fill at or above threshold |
| tmo_req | output | 1 | Inactivity timeout request |
| overrun | output | 1 | Pulse: a character was dropped because the store was full |

## Verification
If the pointers or the count are corrupted, the fault shows on the next read word as a wrong or out-of-order character, or as an empty flag that does not agree with `fill_count`. It also shows in `trig_req` crossing its threshold on the wrong character. A timer that counts wrongly shows as `tmo_req` rising one or more ticks early or late, or staying high after a read or after the store empties. The bench samples these outputs in the cycle right after the edge that should change them.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    typedef struct packed {
        logic       brk;
        logic       err;
        logic [7:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        TM_IDLE = 2'd0,
        TM_RUN  = 2'd1,
        TM_FIRE = 2'd2
    } tm_state_t;

    // Fill threshold for each trigger code; codes past 5 saturate.
    function automatic int unsigned trig_level(input logic [2:0] sel);
        case (sel)
            3'd0:    return 1;
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 16;
            3'd4:    return 32;
            default: return 48;
        endcase
    endfunction

    // Ticks of inactivity per timeout code; 0 means disabled.
    function automatic logic [4:0] idle_limit(input logic [1:0] sel);
        case (sel)
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            2'd3:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_req,
    input  rxq_entry_t               wr_entry,
    input  logic                     rd_req,
    output rxq_entry_t               head,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     empty,
    output logic                     ovr_pulse
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    rxq_entry_t     mem [DEPTH];
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  rd_ptr;
    logic           full;
    logic           wr_ok;
    logic           rd_ok;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign wr_ok = wr_req && !full;
    assign rd_ok = rd_req && !empty;
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            ovr_pulse <= 1'b0;
        end else begin
            ovr_pulse <= wr_req && full;
            if (wr_ok) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (rd_ok) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxq_idle_timer.sv
`timescale 1ns/1ps
module rxq_idle_timer
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       activity,
    input  logic       has_data,
    input  logic [4:0] limit,
    output logic       fire
);
    tm_state_t  st;
    tm_state_t  st_nxt;
    logic [4:0] cnt;
    logic       enabled;
    logic       last_tick;

    assign enabled   = (limit != 5'd0);
    assign last_tick = tick && !activity && (cnt == limit - 5'd1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= TM_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Tick counter, live only in TM_RUN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (st != TM_RUN || activity) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 5'd1;
        end
    end

    // Next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            TM_IDLE: if (has_data && enabled) st_nxt = TM_RUN;
            TM_RUN: begin
                if (!has_data || !enabled) st_nxt = TM_IDLE;
                else if (last_tick)        st_nxt = TM_FIRE;
            end
            TM_FIRE: begin
                if (!has_data || !enabled) st_nxt = TM_IDLE;
                else if (activity)         st_nxt = TM_RUN;
            end
            default: st_nxt = TM_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fire = (st == TM_FIRE);
    end

endmodule

// File: rtl/rx_char_fifo.sv
`timescale 1ns/1ps
module rx_char_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_frame_err,
    input  logic             in_break,
    input  logic             char_tick,
    input  logic             rd_en,
    input  logic [2:0]       trig_sel,
    input  logic [1:0]       tmo_sel,
    output logic [10:0]      rd_word,
    output logic [LVL_W-1:0] fill_count,
    output logic             trig_req,
    output logic             tmo_req,
    output logic             overrun
);
    localparam int CW = $clog2(DEPTH) + 1;

    rxq_entry_t    wr_entry;
    rxq_entry_t    head;
    logic [CW-1:0] count;
    logic          empty;

    assign wr_entry = '{brk: in_break, err: in_frame_err, data: in_byte};

    rxq_store #(.DEPTH(DEPTH)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (in_valid),
        .wr_entry  (wr_entry),
        .rd_req    (rd_en),
        .head      (head),
        .count     (count),
        .empty     (empty),
        .ovr_pulse (overrun)
    );

    rxq_idle_timer i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (char_tick),
        .activity (in_valid || (rd_en && !empty)),
        .has_data (!empty),
        .limit    (idle_limit(tmo_sel)),
        .fire     (tmo_req)
    );

    assign rd_word    = empty ? 11'h100 : {head.brk, head.err, 1'b0, head.data};
    assign fill_count = LVL_W'(count);
    assign trig_req   = (int'(count) >= int'(trig_level(trig_sel)));

endmodule

// File: rtl/rxq_checks.sv
`timescale 1ns/1ps
module rxq_checks #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             rd_en,
    input logic [1:0]       tmo_sel,
    input logic [10:0]      rd_word,
    input logic [LVL_W-1:0] fill_count,
    input logic             trig_req,
    input logic             tmo_req,
    input logic             overrun
);
    // R4: fill never exceeds the depth
    a_r4_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_count) <= DEPTH);

    // R5: overrun only after a character offered to a full store
    a_r5_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(in_valid) && int'($past(fill_count)) == DEPTH));

    // R5: full store with no read keeps its fill when a character arrives
    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rd_en && int'(fill_count) == DEPTH) |=> $stable(fill_count));

    // R7: code 0 keeps the timeout request low
    a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_sel == 2'd0) |=> !tmo_req);

    // R9: timeout request only with data present
    a_r9_tmo_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_req |-> (fill_count != '0));

    // R3: empty flag agrees with fill count
    a_r3_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[8] == (fill_count == '0));

    // R6: trigger implies at least one character stored
    a_r6_trig_data: assert property (@(posedge clk) disable iff (!rst_n)
        trig_req |-> (fill_count != '0));

endmodule

bind rx_char_fifo rxq_checks #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .rd_en      (rd_en),
    .tmo_sel    (tmo_sel),
    .rd_word    (rd_word),
    .fill_count (fill_count),
    .trig_req   (trig_req),
    .tmo_req    (tmo_req),
    .overrun    (overrun)
);

// File: tb/test_rx_char_fifo.sv
`timescale 1ns/1ps
module test_rx_char_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_frame_err = 1'b0;
    logic        in_break = 1'b0;
    logic        char_tick = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  trig_sel = '0;
    logic [1:0]  tmo_sel = '0;
    logic [10:0] rd_word;
    logic [7:0]  fill_count;
    logic        trig_req;
    logic        tmo_req;
    logic        overrun;

    int total = 0;
    int bad = 0;
    logic [10:0] exp_q[$];

    always #2.5 clk = ~clk;

    rx_char_fifo i_rx_char_fifo (
        .clk, .rst_n, .in_valid, .in_byte, .in_frame_err, .in_break,
        .char_tick, .rd_en, .trig_sel, .tmo_sel,
        .rd_word, .fill_count, .trig_req, .tmo_req, .overrun
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_put(input logic [7:0] b, input logic e, input logic k);
        in_valid = 1'b1; in_byte = b; in_frame_err = e; in_break = k;
        if (exp_q.size() < 64) exp_q.push_back({k, e, 1'b0, b});
    endtask

    task automatic put(input logic [7:0] b, input logic e, input logic k);
        drive_put(b, e, k);
        step();
        in_valid = 1'b0;
    endtask

    task automatic rd();
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1;
            step();
            char_tick = 1'b0;
        end
    endtask

    function automatic int thr(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            3: return 16;
            4: return 32;
            default: return 48;
        endcase
    endfunction

    // Monitor: compare presented word against scoreboard on every read (R2, R3)
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            logic [10:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 11'h100;
            chk(rd_word == e, "R2/R3 read word", rd_word, e);
        end
    end

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk(fill_count == 0, "R1 fill", fill_count, 0);
        chk(rd_word == 11'h100, "R1 word", rd_word, 11'h100);
        chk(!trig_req && !tmo_req && !overrun, "R1 flags",
            {trig_req, tmo_req, overrun}, 0);

        // R2 order and flag layout
        put(8'hA5, 1'b0, 1'b0);
        put(8'h3C, 1'b1, 1'b0);
        put(8'h00, 1'b1, 1'b1);
        chk(fill_count == 3, "R4 fill three", fill_count, 3);
        chk(rd_word == 11'h0A5, "R2 head word", rd_word, 11'h0A5);
        rd(); rd(); rd();
        chk(fill_count == 0, "R2 drained", fill_count, 0);

        // R3 read on empty
        rd();
        chk(fill_count == 0, "R3 empty read no change", fill_count, 0);
        chk(rd_word == 11'h100, "R3 empty word", rd_word, 11'h100);

        // R6 thresholds for every code
        for (int c = 0; c < 8; c++) begin
            int t;
            trig_sel = 3'(c);
            t = thr(c);
            for (int i = 0; i < t - 1; i++) put(8'(i + c), 1'b0, 1'b0);
            chk(!trig_req, "R6 below threshold", trig_req, 0);
            put(8'hF0, 1'b0, 1'b1);
            chk(trig_req, "R6 at threshold", trig_req, 1);
            chk(fill_count == 8'(t), "R4 fill at threshold", fill_count, t);
            rd();
            chk(!trig_req, "R6 drops after read", trig_req, 0);
            for (int i = 0; i < t - 1; i++) rd();
        end

        // R4/R5 fill to 64 then overrun
        trig_sel = 3'd5;
        for (int i = 0; i < 64; i++) put(8'(i * 3), i[0], i[1]);
        chk(fill_count == 64, "R4 full", fill_count, 64);
        chk(!overrun, "R5 no overrun yet", overrun, 0);
        put(8'hEE, 1'b0, 1'b0);
        chk(overrun, "R5 overrun pulse", overrun, 1);
        chk(fill_count == 64, "R5 fill kept", fill_count, 64);
        step();
        chk(!overrun, "R5 pulse one cycle", overrun, 0);
        // overrun with simultaneous read: character still dropped
        drive_put(8'hDD, 1'b1, 1'b1);
        rd_en = 1'b1;
        step();
        in_valid = 1'b0; rd_en = 1'b0;
        chk(overrun, "R5 overrun with read", overrun, 1);
        chk(fill_count == 63, "R5 fill after read", fill_count, 63);
        for (int i = 0; i < 63; i++) rd();
        chk(fill_count == 0, "R5 drained", fill_count, 0);

        // R10 simultaneous write and read
        put(8'h11, 1'b0, 1'b0);
        put(8'h22, 1'b0, 1'b0);
        drive_put(8'h33, 1'b0, 1'b0);
        rd_en = 1'b1;
        step();
        in_valid = 1'b0; rd_en = 1'b0;
        chk(fill_count == 2, "R10 fill unchanged", fill_count, 2);
        rd(); rd();

        // R7 timeout per code, R9 clear on empty
        for (int c = 1; c < 4; c++) begin
            int n;
            tmo_sel = 2'(c);
            n = 4 << (c - 1);
            put(8'h55, 1'b0, 1'b0);
            step();
            ticks(n - 1);
            chk(!tmo_req, "R7 before limit", tmo_req, 0);
            ticks(1);
            chk(tmo_req, "R7 at limit", tmo_req, 1);
            rd();
            chk(!tmo_req, "R9 cleared on empty", tmo_req, 0);
        end

        // R8 restart on new character and on read
        tmo_sel = 2'd1;
        put(8'h66, 1'b0, 1'b0);
        step();
        ticks(3);
        put(8'h77, 1'b0, 1'b0);
        ticks(3);
        chk(!tmo_req, "R8 restarted by char", tmo_req, 0);
        ticks(1);
        chk(tmo_req, "R8 fires after restart", tmo_req, 1);
        rd();
        chk(!tmo_req, "R8 withdrawn by read", tmo_req, 0);
        ticks(3);
        chk(!tmo_req, "R8 read restarted count", tmo_req, 0);
        ticks(1);
        chk(tmo_req, "R8 fires after read", tmo_req, 1);
        rd();

        // R9 ticks into empty store
        ticks(20);
        chk(!tmo_req, "R9 empty no timeout", tmo_req, 0);

        // R7 disabled
        tmo_sel = 2'd0;
        put(8'h88, 1'b0, 1'b0);
        ticks(20);
        chk(!tmo_req, "R7 disabled", tmo_req, 0);
        rd();

        step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule